// File: doc/BRIEF.md
# Bus Target Retry-Limit Watchdog

This block sits on the target side of a parallel shared bus, between the bus protocol engine and slow local logic. Each access offered by the engine is answered one cycle later with exactly one of three responses: a normal completion when the local side is ready, a retry (a disconnect with no data moved) when it is not, or a target abort. A bus master must repeat a retried access and has no timeout of its own. A target that keeps retrying can therefore stall the host for good.

The block remembers the address and direction of the access it last retried and counts how often that same access has come back. Once the count reaches a programmable limit, the next unready attempt of that access is ended with a target abort instead. The abort sets a sticky error flag that the host clears by writing 1. The first abort also raises a one-cycle interrupt pulse. A simple strobe handshake stands in for the real bus signals.

Top module: `bus_retry_guard`

## Requirements
- R1: After reset all three response outputs, `retry_count`, `abort_sticky` and `abort_irq` are 0, and `retry_limit` reads 16.
- R2: Every cycle with `req_valid` high produces, in the following cycle only, exactly one of `resp_retry`, `resp_ok`, `resp_abort`. No response appears in any other cycle.
- R3: An access with `local_ready` low whose retry count is below the limit is answered with `resp_retry`, and `retry_count` then shows the count including that retry.
- R4: An access counts as a repeat only when both `req_addr` and `req_write` equal those of the pending retried access. Any other access starts from zero, so its first retry shows `retry_count` = 1.
- R5: An access with `local_ready` high is answered with `resp_ok`, whatever its count, and `retry_count` returns to 0.
- R6: When an unready access arrives whose repeat count already equals the limit, it is answered with `resp_abort` and `retry_count` returns to 0. With a limit of N, the same access gets N retries and then aborts. A limit of 0 aborts on the first unready attempt.
- R7: A cycle with `cfg_limit_we` high loads `cfg_limit` into the limit, visible on `retry_limit` the next cycle and used for later accesses.
- R8: `abort_sticky` is set by every abort and holds until a cycle with `stat_clr` high. When an abort and `stat_clr` coincide, the flag ends up set.
- R9: `abort_irq` pulses for one cycle, together with `resp_abort`, only when that abort moves `abort_sticky` from 0 to 1. An abort while the flag is already set gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe: an access is offered |
| req_addr | input | AW (8) | Address of the offered access |
| req_write | input | 1 | Direction of the offered access, 1 = write |
| local_ready | input | 1 | Local logic can complete the access now |
| cfg_limit_we | input | 1 | Load strobe for the retry limit |
| cfg_limit | input | CW (8) | New retry limit |
| stat_clr | input | 1 | Write-1 clear of the abort flag |
| resp_retry | output | 1 | Access ended with a retry |
| resp_ok | output | 1 | Access completed normally |
| resp_abort | output | 1 | Access ended with a target abort |
| retry_count | output | CW (8) | Retries seen by the pending access |
| retry_limit | output | CW (8) | Current retry limit |
| abort_sticky | output | 1 | Sticky abort error flag |
| abort_irq | output | 1 | One-cycle pulse on the first abort |

## Verification
The bench runs the reset limit of 16 to exhaustion and confirms that the seventeenth attempt aborts. A design that is off by one would abort after 15 or 17 retries. It changes only the direction of a retried access to catch a comparator that ignores `req_write`, which would let the count carry over. It programs a limit of 0 to catch a design that grants one retry before aborting. It fires a second abort while the flag is still set, to catch an interrupt that pulses on every abort. It clears the flag in the same cycle as an abort, to catch a clear that wins over the set and loses the error.

// File: rtl/bus_retry_pkg.sv
package bus_retry_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_RETRY = 2'd1,
        RSP_OK    = 2'd2,
        RSP_ABORT = 2'd3
    } resp_e;

    localparam int unsigned DEFAULT_LIMIT = 16;

endpackage

// File: rtl/bus_retry_match.sv
module bus_retry_match #(
    parameter int unsigned AW = 8
) (
    input  logic          pend_valid,
    input  logic [AW-1:0] pend_addr,
    input  logic          pend_write,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    output logic          same_access
);
    always_comb begin
        same_access = pend_valid && (pend_addr == req_addr) && (pend_write == req_write);
    end
endmodule

// File: rtl/bus_retry_abort_flag.sv
module bus_retry_abort_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
        logic irq;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = set_i && !st_q.flag;
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/bus_retry_guard.sv
module bus_retry_guard
    import bus_retry_pkg::*;
#(
    parameter int unsigned AW        = 8,
    parameter int unsigned CW        = 8,
    parameter int unsigned RST_LIMIT = DEFAULT_LIMIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          local_ready,
    input  logic          cfg_limit_we,
    input  logic [CW-1:0] cfg_limit,
    input  logic          stat_clr,
    output logic          resp_retry,
    output logic          resp_ok,
    output logic          resp_abort,
    output logic [CW-1:0] retry_count,
    output logic [CW-1:0] retry_limit,
    output logic          abort_sticky,
    output logic          abort_irq
);
    localparam logic [CW-1:0] LIMIT_INIT = CW'(RST_LIMIT);
    localparam logic [CW-1:0] ONE        = CW'(1);

    typedef struct packed {
        logic          pend_valid;
        logic [AW-1:0] pend_addr;
        logic          pend_write;
        logic [CW-1:0] count;
        logic [CW-1:0] limit;
        resp_e         resp;
    } guard_t;

    guard_t st_d, st_q;
    logic          same_access;
    logic [CW-1:0] base_count;
    logic          abort_now;

    bus_retry_match #(.AW(AW)) u_match (
        .pend_valid  (st_q.pend_valid),
        .pend_addr   (st_q.pend_addr),
        .pend_write  (st_q.pend_write),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .same_access (same_access)
    );

    always_comb begin
        st_d       = st_q;
        st_d.resp  = RSP_NONE;
        base_count = same_access ? st_q.count : '0;
        abort_now  = 1'b0;

        if (cfg_limit_we) begin
            st_d.limit = cfg_limit;
        end

        if (req_valid) begin
            if (local_ready) begin
                st_d.resp       = RSP_OK;
                st_d.pend_valid = 1'b0;
                st_d.count      = '0;
            end else if (base_count >= st_q.limit) begin
                st_d.resp       = RSP_ABORT;
                st_d.pend_valid = 1'b0;
                st_d.count      = '0;
                abort_now       = 1'b1;
            end else begin
                st_d.resp       = RSP_RETRY;
                st_d.pend_valid = 1'b1;
                st_d.pend_addr  = req_addr;
                st_d.pend_write = req_write;
                st_d.count      = base_count + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.limit <= LIMIT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    bus_retry_abort_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (abort_now),
        .clr_i  (stat_clr),
        .flag_o (abort_sticky),
        .irq_o  (abort_irq)
    );

    assign resp_retry  = (st_q.resp == RSP_RETRY);
    assign resp_ok     = (st_q.resp == RSP_OK);
    assign resp_abort  = (st_q.resp == RSP_ABORT);
    assign retry_count = st_q.count;
    assign retry_limit = st_q.limit;
endmodule

// File: rtl/bus_retry_guard_chk.sv
module bus_retry_guard_chk #(
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          stat_clr,
    input logic          resp_retry,
    input logic          resp_ok,
    input logic          resp_abort,
    input logic [CW-1:0] retry_count,
    input logic          abort_sticky,
    input logic          abort_irq
);
    logic resp_any;
    assign resp_any = resp_retry | resp_ok | resp_abort;

    a_r2_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_retry, resp_ok, resp_abort}));

    a_r2_req_gets_resp: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_any);

    a_r2_no_unasked_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_any |-> $past(req_valid));

    a_r3_retry_counted: assert property (@(posedge clk) disable iff (!rst_n)
        resp_retry |-> (retry_count != '0));

    a_r5_ok_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> (retry_count == '0));

    a_r6_abort_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        resp_abort |-> (retry_count == '0));

    a_r8_abort_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        resp_abort |-> abort_sticky);

    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_sticky && !stat_clr) |=> abort_sticky);

    a_r9_irq_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |-> (resp_abort && $rose(abort_sticky)));

    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_irq |=> !abort_irq);
endmodule

bind bus_retry_guard bus_retry_guard_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .stat_clr     (stat_clr),
    .resp_retry   (resp_retry),
    .resp_ok      (resp_ok),
    .resp_abort   (resp_abort),
    .retry_count  (retry_count),
    .abort_sticky (abort_sticky),
    .abort_irq    (abort_irq)
);

// File: tb/bus_retry_guard_bench.sv
`timescale 1ns/1ps
module bus_retry_guard_bench;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          local_ready = 1'b0;
    logic          cfg_limit_we = 1'b0;
    logic [CW-1:0] cfg_limit = '0;
    logic          stat_clr = 1'b0;
    logic          resp_retry, resp_ok, resp_abort;
    logic [CW-1:0] retry_count, retry_limit;
    logic          abort_sticky, abort_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_retry_guard #(.AW(AW), .CW(CW)) u_bus_retry_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .local_ready(local_ready), .cfg_limit_we(cfg_limit_we),
        .cfg_limit(cfg_limit), .stat_clr(stat_clr), .resp_retry(resp_retry),
        .resp_ok(resp_ok), .resp_abort(resp_abort), .retry_count(retry_count),
        .retry_limit(retry_limit), .abort_sticky(abort_sticky), .abort_irq(abort_irq)
    );

    // response code: 0 none, 1 retry, 2 ok, 3 abort
    // entry: {addr[8], write, ready, code[2], count[8], irq}
    localparam logic [20:0] VEC [NV] = '{
        {8'hA0, 1'b0, 1'b0, 2'd1, 8'd1, 1'b0},  // R3
        {8'hA0, 1'b0, 1'b0, 2'd1, 8'd2, 1'b0},  // R3
        {8'hA0, 1'b0, 1'b0, 2'd1, 8'd3, 1'b0},  // R3
        {8'hA0, 1'b0, 1'b0, 2'd3, 8'd0, 1'b1},  // R6 R9
        {8'hA0, 1'b0, 1'b0, 2'd1, 8'd1, 1'b0},  // R4 after abort
        {8'hB4, 1'b0, 1'b0, 2'd1, 8'd1, 1'b0},  // R4 new address
        {8'hB4, 1'b1, 1'b0, 2'd1, 8'd1, 1'b0},  // R4 new direction
        {8'hB4, 1'b1, 1'b0, 2'd1, 8'd2, 1'b0},  // R4 repeat
        {8'hB4, 1'b1, 1'b1, 2'd2, 8'd0, 1'b0},  // R5
        {8'h3C, 1'b1, 1'b0, 2'd1, 8'd1, 1'b0},  // R3
        {8'h3C, 1'b1, 1'b1, 2'd2, 8'd0, 1'b0}   // R5
    };

    function automatic logic [1:0] resp_code();
        return resp_abort ? 2'd3 : resp_ok ? 2'd2 : resp_retry ? 2'd1 : 2'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [AW-1:0] a, input logic w, input logic rdy, input logic clr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; local_ready = rdy; stat_clr = clr;
        @(negedge clk);
        req_valid = 1'b0; local_ready = 1'b0; stat_clr = 1'b0;
    endtask

    task automatic set_limit(input logic [CW-1:0] v);
        @(negedge clk);
        cfg_limit_we = 1'b1; cfg_limit = v;
        @(negedge clk);
        cfg_limit_we = 1'b0;
        check("R7 limit readback", 32'(retry_limit), 32'(v));
    endtask

    task automatic clear_flag();
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 resp idle", 32'(resp_code()), 32'd0);
        check("R1 count", 32'(retry_count), 32'd0);
        check("R1 limit", 32'(retry_limit), 32'd16);
        check("R1 sticky", 32'(abort_sticky), 32'd0);
        check("R1 irq", 32'(abort_irq), 32'd0);

        // default limit: 16 retries, then abort
        for (int i = 1; i <= 16; i++) begin
            access(8'h55, 1'b1, 1'b0, 1'b0);
            check("R6 default-limit retry", 32'(resp_code()), 32'd1);
            check("R3 count", 32'(retry_count), 32'(i));
        end
        access(8'h55, 1'b1, 1'b0, 1'b0);
        check("R6 default-limit abort", 32'(resp_code()), 32'd3);
        check("R9 first irq", 32'(abort_irq), 32'd1);
        @(negedge clk);
        check("R2 no resp idle", 32'(resp_code()), 32'd0);
        check("R9 irq one cycle", 32'(abort_irq), 32'd0);
        check("R8 sticky holds", 32'(abort_sticky), 32'd1);
        clear_flag();
        check("R8 cleared", 32'(abort_sticky), 32'd0);

        set_limit(8'd3);
        for (int v = 0; v < NV; v++) begin
            access(VEC[v][20:13], VEC[v][12], VEC[v][11], 1'b0);
            check($sformatf("R2/R3/R4/R5/R6 vec %0d resp", v), 32'(resp_code()), 32'(VEC[v][10:9]));
            check($sformatf("R3/R4 vec %0d count", v), 32'(retry_count), 32'(VEC[v][8:1]));
            check($sformatf("R9 vec %0d irq", v), 32'(abort_irq), 32'(VEC[v][0]));
        end
        check("R8 sticky after table", 32'(abort_sticky), 32'd1);

        // second abort while flag set: no irq
        set_limit(8'd0);
        access(8'h11, 1'b0, 1'b0, 1'b0);
        check("R6 limit zero abort", 32'(resp_code()), 32'd3);
        check("R9 no irq when set", 32'(abort_irq), 32'd0);
        clear_flag();
        check("R8 cleared again", 32'(abort_sticky), 32'd0);
        // abort and clear in the same cycle: set wins, irq fires
        access(8'h22, 1'b0, 1'b0, 1'b1);
        check("R6 abort", 32'(resp_code()), 32'd3);
        check("R8 set beats clear", 32'(abort_sticky), 32'd1);
        check("R9 irq on rise", 32'(abort_irq), 32'd1);
        // ready beats limit zero
        access(8'h22, 1'b0, 1'b1, 1'b0);
        check("R5 ok at limit zero", 32'(resp_code()), 32'd2);

        // raise limit, verify new value used
        set_limit(8'd1);
        access(8'h33, 1'b0, 1'b0, 1'b0);
        check("R7 retry under new limit", 32'(resp_code()), 32'd1);
        access(8'h33, 1'b0, 1'b0, 1'b0);
        check("R7 abort under new limit", 32'(resp_code()), 32'd3);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule